// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps an asynchronous DRAM refreshed with CAS-before-RAS cycles. The device counts its refresh rows internally, so no address is produced. A tick timer, derived from the clock period, the row count and the retention period, adds one owed refresh per row interval. Owed refreshes are counted up to a limit, so refreshes held off by long page accesses are made up later. While anything is owed, the block raises a request to the memory controller. When the grant arrives, it drives the RAS, both CAS strobes, write enable and output enable itself. It runs the owed cycles back to back and then drops the request.

After reset the block owns the strobes. It keeps them idle for the power-up pause, runs a fixed number of warm-up CBR cycles, and only then raises `init_done`.

A self-refresh request makes the block refresh every row in one burst and then enter self-refresh. To enter, it lowers CAS, then RAS, and holds both low for at least the minimum self-refresh time. When the request is withdrawn, it precharges for the longer self-refresh recovery time and refreshes every row in a second burst before it gives the bus back.

Top module: `dram_refresh_sched`

## Requirements
- R1: During reset, `ras_n`, `lcas_n` and `ucas_n` are high, `ref_req` is low, `init_done` is low and `drv_en` is high.
- R2: After reset, the strobes stay idle for at least the power-up pause (PAUSE_NS rounded up to clock cycles). Exactly INIT_CYCLES CBR cycles follow, then `init_done` rises. `ref_req` stays low for as long as `init_done` is low.
- R3: Every RAS-low period is a CBR cycle. Both CAS strobes fall at least CSR_NS (in whole cycles) before RAS falls, stay low for the whole time RAS is low, and move together. RAS stays low for at least RAS_NS. `we_n` and `oe_n` are high whenever the block drives the strobes.
- R4: Between consecutive refresh cycles, all strobes stay high for at least RP_NS (in whole cycles).
- R5: One refresh is owed every REFRESH_NS/(ROWS*CLK_NS) cycles, counted from the rise of `init_done`. The owed count saturates at MAX_OWED.
- R6: `ref_req` is high after init while refreshes are owed. No strobe moves until `ref_gnt` is seen high with `ref_req`. The block then runs exactly the owed number of cycles, including any that fall due meanwhile, and drops `ref_req`.
- R7: A `ref_gnt` pulse while `ref_req` is low starts no cycle and leaves the strobes high.
- R8: On `self_req` the block requests the bus. Once granted, it runs ROWS CBR cycles, then lowers CAS and then RAS. `sr_active` is high during the hold, and RAS stays low while `self_req` is high and for at least SELF_MIN_NS.
- R9: On exit from self-refresh, all strobes stay high for at least RPS_NS. ROWS CBR cycles follow, then `ref_req` drops. No refresh owed from before entry survives, and the row-interval timer restarts at the end of the burst.
- R10: When `drv_en` is low, all strobes are high. `drv_en` is low only when the block is idle after init.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_NS |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_gnt | input | 1 | Controller grants the strobes to the scheduler |
| self_req | input | 1 | Level request to enter and stay in self-refresh |
| ref_req | output | 1 | Scheduler asks for the strobes |
| drv_en | output | 1 | Scheduler strobe outputs are to be used |
| ras_n | output | 1 | Row strobe, active low |
| lcas_n | output | 1 | Lower-byte column strobe, active low |
| ucas_n | output | 1 | Upper-byte column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| oe_n | output | 1 | Output enable, held high so the data bus floats |
| init_done | output | 1 | Power-up sequence complete |
| sr_active | output | 1 | Device is held in self-refresh |

## Verification
The assertions assume that the controller raises `ref_gnt` only in answer to `ref_req` and holds it until `ref_req` drops. They also assume that `self_req` is changed only after init. The stimulus keeps to both rules. It drives grant and self-request on falling clock edges, times each grant from the rise of `init_done` so that tick arrivals fall between service windows, and sends the one stray grant pulse while the request is low. The expected sequence of refresh cycles, self-refresh episodes and request drops is queued before each stimulus and compared as the strobe waveform unfolds.

// File: rtl/dram_refresh_sched.sv
`timescale 1ns/1ps
module dram_refresh_sched #(
  parameter int ROWS        = 4096,
  parameter int CLK_NS      = 10,
  parameter int REFRESH_NS  = 64_000_000,
  parameter int PAUSE_NS    = 200_000,
  parameter int SELF_MIN_NS = 100_000,
  parameter int INIT_CYCLES = 8,
  parameter int MAX_OWED    = 8,
  parameter int CSR_NS      = 5,
  parameter int RAS_NS      = 70,
  parameter int RP_NS       = 50,
  parameter int RPS_NS      = 130
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_gnt,
  input  logic self_req,
  output logic ref_req,
  output logic drv_en,
  output logic ras_n,
  output logic lcas_n,
  output logic ucas_n,
  output logic we_n,
  output logic oe_n,
  output logic init_done,
  output logic sr_active
);

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int TICK_CYC  = REFRESH_NS / (ROWS * CLK_NS);
  localparam int PAUSE_CYC = cyc(PAUSE_NS);
  localparam int SRMIN_CYC = cyc(SELF_MIN_NS);
  localparam int CSR_CYC   = cyc(CSR_NS);
  localparam int RAS_CYC   = cyc(RAS_NS);
  localparam int RP_CYC    = cyc(RP_NS);
  localparam int RPS_CYC   = cyc(RPS_NS);
  localparam int TMAX      = (PAUSE_CYC > RPS_CYC) ? PAUSE_CYC : RPS_CYC;
  localparam int TW        = $clog2(TMAX + 1);
  localparam int LMAX      = (ROWS > INIT_CYCLES) ? ROWS : INIT_CYCLES;
  localparam int LW        = $clog2(LMAX + 1);
  localparam int OW        = $clog2(MAX_OWED + 1);
  localparam int KW        = $clog2(TICK_CYC + 1);
  localparam int SW        = $clog2(SRMIN_CYC + 1);

  typedef enum logic [2:0] {
    ST_PAUSE, ST_IDLE, ST_CAS, ST_RAS, ST_PRE, ST_SR_CAS, ST_SR_HOLD, ST_SR_PRE
  } st_t;
  typedef enum logic [2:0] {J_NONE, J_INIT, J_OWED, J_PRE, J_POST} job_t;

  st_t           st;
  job_t          job;
  logic [TW-1:0] tmr;
  logic [LW-1:0] left;
  logic [OW-1:0] owed, owed_nxt;
  logic [OW:0]   owed_sum;
  logic [KW-1:0] tcnt;
  logic [SW-1:0] sr_cnt;
  logic          done_q;

  wire last_ph  = (tmr == '0);
  wire tick_hit = done_q && (tcnt == KW'(TICK_CYC - 1));
  wire accrue   = tick_hit && (job == J_NONE || job == J_OWED);
  wire cyc_end  = (st == ST_PRE) && last_ph;
  wire owed_dec = cyc_end && (job == J_OWED);
  wire cas_low  = (st == ST_CAS) || (st == ST_RAS) || (st == ST_SR_CAS) || (st == ST_SR_HOLD);
  wire ras_low  = (st == ST_RAS) || (st == ST_SR_HOLD);

  always_comb begin
    owed_sum = {1'b0, owed} + (OW+1)'(accrue) - (OW+1)'(owed_dec);
    owed_nxt = (owed_sum > (OW+1)'(MAX_OWED)) ? OW'(MAX_OWED) : owed_sum[OW-1:0];
  end

  assign ref_req   = done_q && (st != ST_IDLE || self_req || owed != '0);
  assign drv_en    = !done_q || st != ST_IDLE;
  assign ras_n     = !ras_low;
  assign lcas_n    = !cas_low;
  assign ucas_n    = !cas_low;
  assign we_n      = 1'b1;
  assign oe_n      = 1'b1;
  assign init_done = done_q;
  assign sr_active = (st == ST_SR_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_PAUSE;
      job    <= J_INIT;
      tmr    <= TW'(PAUSE_CYC - 1);
      left   <= LW'(INIT_CYCLES);
      owed   <= '0;
      tcnt   <= '0;
      sr_cnt <= '0;
      done_q <= 1'b0;
    end else begin
      owed <= owed_nxt;
      if (done_q) tcnt <= tick_hit ? '0 : tcnt + 1'b1;
      if (!last_ph) tmr <= tmr - 1'b1;
      case (st)
        ST_PAUSE: if (last_ph) begin
          st  <= ST_CAS;
          tmr <= TW'(CSR_CYC - 1);
        end
        ST_IDLE: if (ref_req && ref_gnt) begin
          if (self_req) begin
            job  <= J_PRE;
            left <= LW'(ROWS);
          end else begin
            job <= J_OWED;
          end
          st  <= ST_CAS;
          tmr <= TW'(CSR_CYC - 1);
        end
        ST_CAS: if (last_ph) begin
          st  <= ST_RAS;
          tmr <= TW'(RAS_CYC - 1);
        end
        ST_RAS: if (last_ph) begin
          st  <= ST_PRE;
          tmr <= TW'(RP_CYC - 1);
        end
        ST_PRE: if (last_ph) begin
          st  <= ST_CAS;
          tmr <= TW'(CSR_CYC - 1);
          case (job)
            J_INIT: if (left == LW'(1)) begin
              done_q <= 1'b1;
              job    <= J_NONE;
              st     <= ST_IDLE;
              tcnt   <= '0;
            end else left <= left - 1'b1;
            J_OWED: if (owed_nxt == '0) begin
              job <= J_NONE;
              st  <= ST_IDLE;
            end
            J_PRE: begin
              if (left == LW'(1)) st <= ST_SR_CAS;
              else left <= left - 1'b1;
            end
            J_POST: if (left == LW'(1)) begin
              job  <= J_NONE;
              st   <= ST_IDLE;
              tcnt <= '0;
              owed <= '0;
            end else left <= left - 1'b1;
            default: st <= ST_IDLE;
          endcase
        end
        ST_SR_CAS: if (last_ph) begin
          st     <= ST_SR_HOLD;
          sr_cnt <= '0;
          owed   <= '0;
        end
        ST_SR_HOLD: begin
          if (sr_cnt != SW'(SRMIN_CYC)) sr_cnt <= sr_cnt + 1'b1;
          if (!self_req && sr_cnt >= SW'(SRMIN_CYC - 1)) begin
            st  <= ST_SR_PRE;
            tmr <= TW'(RPS_CYC - 1);
          end
        end
        ST_SR_PRE: if (last_ph) begin
          job  <= J_POST;
          left <= LW'(ROWS);
          st   <= ST_CAS;
          tmr  <= TW'(CSR_CYC - 1);
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R2
  no_req_in_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !ref_req);
  // R3
  cas_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $past(!lcas_n && !ucas_n));
  // R3
  cas_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> (!lcas_n && !ucas_n));
  // R4
  pre_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |=> (ras_n && lcas_n && ucas_n));
  // R5
  owed_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    owed <= OW'(MAX_OWED));
  // R6
  start_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(lcas_n) && $past(st == ST_IDLE)) |-> $past(ref_gnt && ref_req));
  // R10
  idle_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_en |-> (ras_n && lcas_n && ucas_n));

endmodule

// File: tb/dram_refresh_sched_bench.sv
`timescale 1ns/1ps
module dram_refresh_sched_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TICK  = 100;
  localparam int PAUSE = 200;
  localparam int SRMIN = 100;
  localparam int T_CSR = 1;
  localparam int T_RAS = 7;
  localparam int T_RP  = 5;
  localparam int T_RPS = 13;
  localparam int NROWS = 16;
  localparam int EV_C = 1, EV_S = 2, EV_D = 3, EV_R = 4, EV_BAD = 5;

  logic clk = 0, rst_n = 0, ref_gnt = 0, self_req = 0;
  logic ref_req, drv_en, ras_n, lcas_n, ucas_n, we_n, oe_n, init_done, sr_active;

  dram_refresh_sched #(
    .ROWS(NROWS), .CLK_NS(CLK_PERIOD), .REFRESH_NS(TICK*NROWS*CLK_PERIOD),
    .PAUSE_NS(PAUSE*CLK_PERIOD), .SELF_MIN_NS(SRMIN*CLK_PERIOD),
    .INIT_CYCLES(8), .MAX_OWED(4), .CSR_NS(5), .RAS_NS(70), .RP_NS(50), .RPS_NS(130)
  ) u_dram_refresh_sched (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .self_req(self_req),
    .ref_req(ref_req), .drv_en(drv_en), .ras_n(ras_n), .lcas_n(lcas_n),
    .ucas_n(ucas_n), .we_n(we_n), .oe_n(oe_n), .init_done(init_done),
    .sr_active(sr_active)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { int code; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic expect_ev(input int code, input string tag);
    exp_t e;
    e.code = code; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic emit(input int code);
    exp_t e;
    if (q.size() == 0) chk(0, "R7 unexpected event", code, 0);
    else begin
      e = q.pop_front();
      chk(code == e.code, e.tag, code, e.code);
    end
  endtask

  always @(posedge clk) if (init_done) cyc <= cyc + 1;

  // monitor
  int cas_lead = 0, ras_low = 0, hi_gap = 0;
  bit prev_ras = 1, prev_cas = 1, prev_req = 0, prev_done = 0, last_s = 0, seen = 0;
  bit bad_init_req = 0, bad_idle = 0, bad_we = 0, bad_split = 0, bad_hold = 0;
  always @(negedge clk) if (rst_n) begin
    if (!init_done && ref_req) bad_init_req = 1;
    if (!drv_en && !(ras_n && lcas_n && ucas_n)) bad_idle = 1;
    if (drv_en && !(we_n && oe_n)) bad_we = 1;
    if (lcas_n != ucas_n) bad_split = 1;
    if (ras_n) begin
      if (!prev_ras) begin
        last_s = (ras_low >= SRMIN);
        emit(ras_low >= SRMIN ? EV_S : (ras_low >= T_RAS ? EV_C : EV_BAD));
        hi_gap = 0;
      end
      if (!lcas_n) begin
        if (prev_cas) begin
          if (seen) chk(hi_gap >= (last_s ? T_RPS : T_RP), last_s ? "R9 recovery" : "R4 precharge",
                        hi_gap, last_s ? T_RPS : T_RP);
          seen = 1;
          cas_lead = 0;
        end
        cas_lead++;
      end else hi_gap++;
    end else begin
      if (prev_ras) begin
        chk(!lcas_n && cas_lead >= T_CSR, "R3 cas lead", cas_lead, T_CSR);
        ras_low = 0;
      end
      ras_low++;
      if (lcas_n) bad_hold = 1;
    end
    if (prev_req && !ref_req) emit(EV_R);
    if (!prev_done && init_done) emit(EV_D);
    prev_ras = ras_n; prev_cas = lcas_n; prev_req = ref_req; prev_done = init_done;
  end

  task automatic wait_until(input int k);
    while (cyc < k) @(negedge clk);
  endtask

  task automatic serve(input int n, input string tag);
    for (int i = 0; i < n; i++) expect_ev(EV_C, tag);
    expect_ev(EV_R, tag);
    ref_gnt = 1;
    for (int i = 0; i < 2000 && ref_req; i++) @(negedge clk);
    ref_gnt = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int cnt;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(ras_n && lcas_n && ucas_n, "R1 strobes", {ras_n, lcas_n, ucas_n}, 7);
    chk(!ref_req && !init_done, "R1 req/init", {ref_req, init_done}, 0);
    chk(drv_en, "R1 drv_en", drv_en, 1);
    for (int i = 0; i < 8; i++) expect_ev(EV_C, "R2 init cycles");
    expect_ev(EV_D, "R2 init done");
    rst_n = 1;
    cnt = 0;
    @(negedge clk);
    while (lcas_n && cnt < 5000) begin cnt++; @(negedge clk); end
    chk(cnt >= PAUSE - 1, "R2 pause", cnt, PAUSE - 1);
    wait (init_done);
    wait_until(50);
    chk(!ref_req, "R5 nothing owed yet", ref_req, 0);
    wait_until(150);
    chk(ref_req, "R5 owed after tick", ref_req, 1);
    wait_until(220);
    serve(2, "R6 two owed");
    wait_until(260);
    ref_gnt = 1;
    repeat (5) @(negedge clk);
    ref_gnt = 0;
    chk(ras_n && lcas_n && !drv_en, "R7 stray grant", {ras_n, lcas_n, drv_en}, 6);
    wait_until(920);
    serve(4, "R5 saturation");
    wait_until(1020);
    for (int i = 0; i < NROWS; i++) expect_ev(EV_C, "R8 entry burst");
    expect_ev(EV_S, "R8 self hold");
    for (int i = 0; i < NROWS; i++) expect_ev(EV_C, "R9 exit burst");
    expect_ev(EV_R, "R9 release");
    self_req = 1;
    ref_gnt = 1;
    cnt = 0;
    while (!sr_active && cnt < 2000) begin cnt++; @(negedge clk); end
    repeat (30) @(negedge clk);
    chk(sr_active && !ras_n, "R8 hold active", {sr_active, ras_n}, 2);
    self_req = 0;
    for (int i = 0; i < 3000 && ref_req; i++) @(negedge clk);
    ref_gnt = 0;
    repeat (50) @(negedge clk);
    chk(!ref_req, "R9 owed cleared", ref_req, 1'b0);
    repeat (60) @(negedge clk);
    chk(ref_req, "R9 timer restart", ref_req, 1);
    serve(1, "R9 first tick after exit");
    repeat (5) @(negedge clk);
    chk(q.size() == 0, "R6 all events seen", q.size(), 0);
    chk(!bad_init_req, "R2 req during init", bad_init_req, 0);
    chk(!bad_idle, "R10 idle strobes", bad_idle, 0);
    chk(!bad_we, "R3 we/oe high", bad_we, 0);
    chk(!bad_split && !bad_hold, "R3 cas together and held", {bad_split, bad_hold}, 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule